// File: doc/BRIEF.md
# Shadowed SRAM Port

This block is a byte-wide static memory port with a second, hidden copy of the array behind it. An external agent uses the familiar active-low trio of chip enable, output enable and write enable, an 11-bit address and a data bus. The bus is split into an input byte, an output byte and an output-drive flag, and a pad ring elsewhere turns these into a tri-state pin. All pins are sampled on a system clock, so every strobe edge is seen as a change between two consecutive samples.

Behind the working array sits a shadow array of the same size. A sequencer outside the block can ask for a whole-array copy in either direction: working to shadow (save) or shadow to working (restore). The copy moves one byte per clock and ends with a single-cycle done pulse. A write-inhibit input blocks array updates from the pins, and also blocks save requests, as a low-supply guard would. Restore is still allowed while it is high.

Top module: `shadow_sram_port`

## Requirements
- R1: While reset is held and until the third clock edge after `rst_n` rises, `dq_oe`, `copy_busy`, `copy_done` and `proto_err` are 0.
- R2: When a clock edge samples `ce_n`=0, `oe_n`=0 and `we_n`=1, `dq_oe` is 1 after that edge and `dq_out` holds the working byte at the sampled address. The output follows each new address with no strobe toggling.
- R3: `dq_oe` is 0 after any edge that samples `ce_n`=1, `oe_n`=1 or `we_n`=0.
- R4: If the sample in which `ce_n` first reads 0 also has `we_n`=0, `dq_oe` stays 0 for the whole enable period, even after `we_n` returns high. It clears only when `ce_n` is sampled high.
- R5: A write is committed in the first sample where `ce_n` or `we_n` reads 1, provided the previous sample had both at 0. Address and data are taken from that terminating sample. A read in the same sample returns the newly written byte.
- R6: A write whose terminating sample has `wr_inhibit`=1 leaves the working array unchanged.
- R7: If two consecutive samples both have `ce_n`=0 and `we_n`=0 with different addresses, `proto_err` is 1 for exactly the one cycle after the second of them.
- R8: When `copy_req`=1 is sampled while idle, a copy starts. `copy_dir`=0 copies working to shadow, and `copy_dir`=1 copies shadow to working. `copy_busy` is 1 for exactly 2048 cycles, and `copy_done` is 1 for the one cycle after the last of them.
- R9: A request with `copy_dir`=0 is ignored while `wr_inhibit`=1. A request with `copy_dir`=1 proceeds regardless of `wr_inhibit`.
- R10: While a copy runs, `dq_oe` stays 0, write commits from the pins are discarded, and further copy requests are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| dq_in | input | 8 | Write data from the bus |
| dq_out | output | 8 | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable |
| wr_inhibit | input | 1 | Blocks pin writes and save requests |
| copy_req | input | 1 | Start a whole-array copy |
| copy_dir | input | 1 | 0: working to shadow, 1: shadow to working |
| copy_busy | output | 1 | Copy in progress |
| copy_done | output | 1 | One-cycle pulse after the last byte |
| proto_err | output | 1 | Address moved inside a write |

## Verification
The hardest state to reach is a restore that lands on a working array whose contents differ from the shadow. The stimulus fills every working location with a known pattern and saves it. It then overwrites chosen bytes and restores, so that a lost, stale or misindexed byte shows up on a later read. Pin activity is also injected in the middle of a save: a read, a complete write and a repeat request. A per-clock behavioural model then confirms that none of these reach the bus or the array.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic {
    CPY_TO_SHADOW = 1'b0,
    CPY_TO_WORK   = 1'b1
  } cpy_dir_e;
endpackage

// File: rtl/srp_bank.sv
module srp_bank #(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int NUM_RD = 1
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [NUM_RD-1:0][AW-1:0]    rd_addr,
  output logic [NUM_RD-1:0][DW-1:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/srp_copy.sv
module srp_copy
  import srp_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          dir,
  input  logic          inhibit,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] idx,
  output logic          to_shadow_we,
  output logic          to_work_we
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [AW-1:0] idx_q, idx_d;
  cpy_dir_e      dir_q, dir_d;
  logic          start_ok;

  always_comb begin
    busy_d   = busy_q;
    idx_d    = idx_q;
    dir_d    = dir_q;
    done_d   = 1'b0;
    start_ok = req && !((cpy_dir_e'(dir) == CPY_TO_SHADOW) && inhibit);
    if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (start_ok) begin
      busy_d = 1'b1;
      idx_d  = '0;
      dir_d  = cpy_dir_e'(dir);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      dir_q  <= CPY_TO_SHADOW;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      dir_q  <= dir_d;
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign idx          = idx_q;
  assign to_shadow_we = busy_q && (dir_q == CPY_TO_SHADOW);
  assign to_work_we   = busy_q && (dir_q == CPY_TO_WORK);

  // R8
  copy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx == AW'($past(idx) + 1'b1)));

  // R9
  store_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req) && !($past(inhibit) && !$past(dir))));
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          inhibit,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic          commit_we,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          proto_err
);
  logic          ce_prev_q;
  logic          act_q;
  logic [AW-1:0] addr_q;
  logic          blank_q, blank_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          doe_q, doe_d;
  logic          err_q, err_d;
  logic          act_now, term;

  always_comb begin
    act_now   = !ce_n && !we_n;
    term      = act_q && !act_now;
    commit_we = term && !inhibit && !busy;
    err_d     = act_q && act_now && (addr != addr_q);
    if (ce_n) begin
      blank_d = 1'b0;
    end else if (ce_prev_q) begin
      blank_d = !we_n;
    end else begin
      blank_d = blank_q;
    end
    doe_d  = !busy && !ce_n && !oe_n && we_n && !blank_d;
    dout_d = commit_we ? din : rd_data;
  end

  assign commit_addr = addr;
  assign commit_data = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_q <= 1'b1;
      act_q     <= 1'b0;
      addr_q    <= '0;
      blank_q   <= 1'b0;
      dout_q    <= '0;
      doe_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ce_prev_q <= ce_n;
      act_q     <= act_now;
      blank_q   <= blank_d;
      doe_q     <= doe_d;
      err_q     <= err_d;
      if (act_now) begin
        addr_q <= addr;
      end
      if (doe_d) begin
        dout_q <= dout_d;
      end
    end
  end

  assign dq_out    = dout_q;
  assign dq_oe     = doe_q;
  assign proto_err = err_q;

  // R2
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ($past(!ce_n) && $past(!oe_n)));

  // R3
  bus_quiet_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(we_n));

  // R7
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(addr) != $past(addr, 2)));
endmodule

// File: rtl/shadow_sram_port.sv
module shadow_sram_port #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              wr_inhibit,
  input  logic              copy_req,
  input  logic              copy_dir,
  output logic              copy_busy,
  output logic              copy_done,
  output logic              proto_err
);
  logic [1:0]              rst_sync_q;
  logic                    rst_core_n;
  logic                    commit_we;
  logic [ADDR_W-1:0]       commit_addr;
  logic [DATA_W-1:0]       commit_data;
  logic [ADDR_W-1:0]       copy_idx;
  logic                    to_shadow_we, to_work_we;
  logic [1:0][ADDR_W-1:0]  work_raddr;
  logic [1:0][DATA_W-1:0]  work_rdata;
  logic [0:0][ADDR_W-1:0]  shad_raddr;
  logic [0:0][DATA_W-1:0]  shad_rdata;
  logic                    work_we;
  logic [ADDR_W-1:0]       work_waddr;
  logic [DATA_W-1:0]       work_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  srp_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .addr        (addr),
    .din         (dq_in),
    .inhibit     (wr_inhibit),
    .busy        (copy_busy),
    .rd_data     (work_rdata[0]),
    .commit_we   (commit_we),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .proto_err   (proto_err)
  );

  srp_copy #(.AW(ADDR_W)) u_copy (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .req          (copy_req),
    .dir          (copy_dir),
    .inhibit      (wr_inhibit),
    .busy         (copy_busy),
    .done         (copy_done),
    .idx          (copy_idx),
    .to_shadow_we (to_shadow_we),
    .to_work_we   (to_work_we)
  );

  always_comb begin
    work_raddr[0] = addr;
    work_raddr[1] = copy_idx;
    shad_raddr[0] = copy_idx;
    work_we       = commit_we || to_work_we;
    work_waddr    = to_work_we ? copy_idx      : commit_addr;
    work_wdata    = to_work_we ? shad_rdata[0] : commit_data;
  end

  srp_bank #(.AW(ADDR_W), .DW(DATA_W), .NUM_RD(2)) u_work (
    .clk     (clk),
    .wr_en   (work_we),
    .wr_addr (work_waddr),
    .wr_data (work_wdata),
    .rd_addr (work_raddr),
    .rd_data (work_rdata)
  );

  srp_bank #(.AW(ADDR_W), .DW(DATA_W), .NUM_RD(1)) u_shadow (
    .clk     (clk),
    .wr_en   (to_shadow_we),
    .wr_addr (copy_idx),
    .wr_data (work_rdata[1]),
    .rd_addr (shad_raddr),
    .rd_data (shad_rdata)
  );

  // R10
  bus_off_in_copy_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(copy_busy) |-> !dq_oe);
endmodule

// File: tb/shadow_sram_port_bench.sv
module shadow_sram_port_bench;
  logic        clk;
  logic        rst_n;
  logic        ce_n, oe_n, we_n;
  logic [10:0] addr;
  logic [7:0]  dq_in;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic        wr_inhibit, copy_req, copy_dir;
  logic        copy_busy, copy_done, proto_err;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;
  bit finished = 0;

  shadow_sram_port u_shadow_sram_port (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .wr_inhibit(wr_inhibit), .copy_req(copy_req), .copy_dir(copy_dir),
    .copy_busy(copy_busy), .copy_done(copy_done), .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] work_m [2048];
  logic [7:0] shad_m [2048];
  int   rc = 0;
  bit   p_ce = 1, p_act = 0, blank_m = 0, busy_m = 0, dir_m = 0;
  int   idx_m = 0;
  int   p_addr = 0;
  bit   exp_oe = 0, exp_done = 0, exp_err = 0, exp_busy = 0;
  logic [7:0] exp_out = 8'h00;

  always @(posedge clk) begin
    bit was_busy, act;
    if (!rst_n || rc < 2) begin
      if (!rst_n) rc = 0; else rc = rc + 1;
      p_ce = 1; p_act = 0; blank_m = 0; busy_m = 0; idx_m = 0;
      exp_oe = 0; exp_done = 0; exp_err = 0; exp_busy = 0; exp_out = 8'h00;
    end else begin
      was_busy = busy_m;
      act = !ce_n && !we_n;
      exp_done = 0;
      exp_err = 0;
      if (was_busy) begin
        if (dir_m == 0) shad_m[idx_m] = work_m[idx_m];
        else            work_m[idx_m] = shad_m[idx_m];
        if (idx_m == 2047) begin busy_m = 0; exp_done = 1; end
        else idx_m = idx_m + 1;
      end else begin
        if (p_act && !act && !wr_inhibit) work_m[addr] = dq_in;
        if (copy_req && !(copy_dir == 1'b0 && wr_inhibit)) begin
          busy_m = 1; idx_m = 0; dir_m = copy_dir;
        end
      end
      if (p_act && act && (int'(addr) != p_addr)) exp_err = 1;
      if (ce_n) blank_m = 0;
      else if (p_ce) blank_m = !we_n;
      exp_oe = !was_busy && !ce_n && !oe_n && we_n && !blank_m;
      if (exp_oe) exp_out = work_m[addr];
      exp_busy = busy_m;
      p_ce = ce_n;
      p_act = act;
      p_addr = int'(addr);
    end
  end

  task automatic check(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      check("R2 dq_oe vs model", int'(dq_oe), int'(exp_oe));
      if (exp_oe) check("R5 dq_out vs model", int'(dq_out), int'(exp_out));
      check("R8 copy_busy vs model", int'(copy_busy), int'(exp_busy));
      check("R8 copy_done vs model", int'(copy_done), int'(exp_done));
      check("R7 proto_err vs model", int'(proto_err), int'(exp_err));
    end
  end

  // ---------------- stimulus ----------------
  task automatic pins(bit c, bit o, bit w, int a, int d, bit inh);
    ce_n = c; oe_n = o; we_n = w;
    addr = 11'(a); dq_in = 8'(d); wr_inhibit = inh;
    @(negedge clk);
  endtask

  task automatic idle();
    pins(1, 1, 1, 0, 0, 0);
  endtask

  task automatic start_copy(bit dir, bit inh);
    ce_n = 1; oe_n = 1; we_n = 1; wr_inhibit = inh;
    copy_req = 1; copy_dir = dir;
    @(negedge clk);
    copy_req = 0; wr_inhibit = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && copy_busy; i++) idle();
  endtask

  task automatic read_at(int a);
    pins(0, 0, 1, a, 0, 0);
  endtask

  initial begin
    int n;
    rst_n = 1; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; dq_in = '0;
    wr_inhibit = 0; copy_req = 0; copy_dir = 0;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    cmp_en = 1;
    // R1 reset state
    check("R1 dq_oe in reset", int'(dq_oe), 0);
    check("R1 busy in reset", int'(copy_busy), 0);
    check("R1 done/err in reset", int'(copy_done | proto_err), 0);
    rst_n = 1;
    idle(); idle(); idle();
    check("R1 dq_oe after release", int'(dq_oe), 0);

    // fill working array (R5 commit on terminating sample)
    for (int a = 0; a < 2048; a++) begin
      pins(0, 1, 0, a, pat(a), 0);
      pins(0, 1, 1, a, pat(a), 0);
    end
    idle();

    // R2 reads follow address
    read_at(5);
    check("R2 read 5 oe", int'(dq_oe), 1);
    check("R2 read 5 data", int'(dq_out), int'(pat(5)));
    read_at(2047);
    check("R2 read top address", int'(dq_out), int'(pat(2047)));
    read_at(0);
    check("R2 read address 0", int'(dq_out), int'(pat(0)));

    // R3 drive drops
    pins(0, 0, 0, 0, 8'h77, 0);
    check("R3 we low stops drive", int'(dq_oe), 0);
    pins(0, 1, 1, 0, 0, 0);
    check("R3 oe high stops drive", int'(dq_oe), 0);
    pins(1, 0, 1, 0, 0, 0);
    check("R3 ce high stops drive", int'(dq_oe), 0);

    // R5 write then same-sample read
    pins(0, 1, 1, 10, 0, 0);
    pins(0, 1, 0, 10, 8'hA5, 0);
    pins(0, 0, 1, 10, 8'hA5, 0);
    check("R5 same-sample read oe", int'(dq_oe), 1);
    check("R5 same-sample read data", int'(dq_out), 8'hA5);

    // R6 inhibited write
    idle();
    pins(0, 1, 1, 11, 0, 0);
    pins(0, 1, 0, 11, 8'h5A, 0);
    pins(0, 0, 1, 11, 8'h5A, 1);
    check("R6 inhibited write keeps old", int'(dq_out), int'(pat(11)));

    // R4 ce falls with we low
    idle();
    pins(0, 1, 0, 30, 8'h3C, 0);
    pins(0, 0, 1, 30, 8'h3C, 0);
    check("R4 blanked after we rises", int'(dq_oe), 0);
    pins(0, 0, 1, 30, 0, 0);
    check("R4 still blanked", int'(dq_oe), 0);
    pins(1, 0, 1, 30, 0, 0);
    pins(0, 0, 1, 30, 0, 0);
    check("R4 drive after new enable", int'(dq_oe), 1);
    check("R4 written byte", int'(dq_out), 8'h3C);

    // R7 address moves inside a write
    idle();
    pins(0, 1, 0, 20, 8'h33, 0);
    pins(0, 1, 0, 21, 8'h44, 0);
    check("R7 error pulse", int'(proto_err), 1);
    pins(0, 1, 1, 21, 8'h44, 0);
    check("R7 pulse one cycle", int'(proto_err), 0);
    idle();

    // R8 save copy, busy length and done
    start_copy(0, 0);
    n = 0;
    while (copy_busy && n < 3000) begin n++; idle(); end
    check("R8 busy cycles", n, 2048);
    check("R8 done after last", int'(copy_done), 1);
    idle();
    check("R8 done single cycle", int'(copy_done), 0);

    // R8 restore overwrites modified byte
    pins(0, 1, 0, 10, 8'h00, 0);
    pins(0, 1, 1, 10, 8'h00, 0);
    idle();
    start_copy(1, 0);
    wait_idle();
    idle();
    read_at(10);
    check("R8 restore byte 10", int'(dq_out), 8'hA5);
    read_at(21);
    check("R8 restore byte 21", int'(dq_out), 8'h44);

    // R9 save blocked under inhibit, restore allowed
    idle();
    start_copy(0, 1);
    check("R9 save ignored", int'(copy_busy), 0);
    start_copy(1, 1);
    check("R9 restore proceeds", int'(copy_busy), 1);
    wait_idle();
    idle();

    // R10 pin activity during a save
    start_copy(0, 0);
    read_at(5);
    check("R10 no drive in copy", int'(dq_oe), 0);
    pins(1, 1, 1, 6, 0, 0);
    pins(0, 1, 0, 6, 8'hEE, 0);
    pins(0, 1, 1, 6, 8'hEE, 0);
    copy_req = 1; copy_dir = 1; idle(); copy_req = 0;
    wait_idle();
    idle();
    check("R10 no extra copy", int'(copy_busy), 0);
    read_at(6);
    check("R10 write discarded", int'(dq_out), int'(pat(6)));
    idle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL R8 watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule